// File: doc/BRIEF.md
# CAN Transmit Object Pre-Arbitration Controller

This block holds a bank of transmit message objects for a CAN controller. Each object carries an enable flag, a remote-request flag, an interrupt-enable flag and an identifier. Whenever the CAN core is not already busy with a frame from this block, the controller picks one enabled object and hands its index to the core. The core later reports the outcome with a done pulse and a success flag.

Selection goes by object number and not by identifier priority. The lowest enabled index always wins. Software can therefore queue the frames of a fragmented message in consecutive objects that share one identifier, and the frames go out in index order. A successful completion clears the object's enable flag and can raise that object's interrupt. A remote-request object is also cancelled without an interrupt when the receive path reports an incoming frame with the same identifier. The bit-level protocol, data movement and receive filtering are handled elsewhere.

Top module: `can_txobj_arb`

## Requirements
- R1: After a synchronous reset, `sel_valid` is 0, `irq` is all zeros and every object is disabled, so no selection is made until software enables an object.
- R2: A write with `cfg_we` high loads the object at `cfg_idx` from `cfg_ctrl` and `cfg_id`, using bit 0 = remote-request flag, bit 1 = interrupt enable and bit 2 = enable. When the block is idle, a newly enabled object is presented on `sel_valid` in the second cycle after the write edge.
- R3: Among all enabled objects, the selection is always the one with the lowest index.
- R4: `sel_valid` is a one-cycle strobe. No further strobe occurs until `core_done` has closed the outstanding selection.
- R5: A `core_done` pulse with `core_ok` high clears the enable flag of the selected object, whether it is a data object or a remote-request object. Arbitration resumes in the cycle after the done edge.
- R6: A `core_done` pulse with `core_ok` low leaves the object enabled, so the same object is selected again.
- R7: In the cycle after a successful done, `irq` carries a one-cycle pulse on the bit of the selected object, and only if that object's interrupt enable is set. Otherwise `irq` stays all zeros.
- R8: An `rx_match` pulse whose `rx_id` equals the identifier of an enabled remote-request object clears that object's enable flag without an interrupt. Data objects with the same identifier are not affected.
- R9: If the cancelled remote-request object is the one currently being transmitted, its later successful completion raises no interrupt.
- R10: Objects that share an identifier are selected in increasing index order, which queues the frames of a fragmented message.
- R11: `sel_rtr` reports the remote-request flag of the selected object alongside `sel_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Object write strobe |
| cfg_idx | input | 5 | Object number to write |
| cfg_ctrl | input | 3 | {enable, irq enable, remote-request} |
| cfg_id | input | 29 | Identifier to store |
| core_done | input | 1 | Core finished the outstanding frame |
| core_ok | input | 1 | Frame was sent successfully (qualifies core_done) |
| rx_match | input | 1 | Received frame matched an identifier |
| rx_id | input | 29 | Identifier of the received frame |
| sel_valid | output | 1 | One-cycle strobe for a new selection |
| sel_idx | output | 5 | Selected object number |
| sel_rtr | output | 1 | Selected object sends a remote-request frame |
| irq | output | 32 | Per-object completion interrupt pulses |

## Verification
The assertions assume that `core_done` arrives only while a selection is outstanding and never in the same cycle as the strobe that opens it. They also assume that software does not rewrite the object that is currently in transmission. The bench drives the done pulse only after it has seen the strobe, and it writes only to objects that are not selected. Receive-match pulses may arrive at any time, both before and during a transmission, because the cancellation rules cover both cases.

// File: rtl/can_txobj_pkg.sv
package can_txobj_pkg;
  localparam int CTRL_W    = 3;
  localparam int CTRL_RTR  = 0;
  localparam int CTRL_IE   = 1;
  localparam int CTRL_EN   = 2;
endpackage

// File: rtl/txobj_bank.sv
module txobj_bank #(
  parameter int N_OBJ = 32,
  parameter int ID_W  = 29,
  localparam int IW   = $clog2(N_OBJ)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IW-1:0]              wr_idx,
  input  logic [2:0]                 wr_ctrl,
  input  logic [ID_W-1:0]            wr_id,
  input  logic                       fin_en,
  input  logic [IW-1:0]              fin_idx,
  input  logic [N_OBJ-1:0]           kill,
  output logic [N_OBJ-1:0]           en_q,
  output logic [N_OBJ-1:0]           rtr_q,
  output logic [N_OBJ-1:0]           ie_q,
  output logic [N_OBJ-1:0][ID_W-1:0] id_q
);
  import can_txobj_pkg::*;

  for (genvar g = 0; g < N_OBJ; g++) begin : g_obj
    logic hit_wr, hit_fin;
    assign hit_wr  = wr_en  && (wr_idx  == IW'(g));
    assign hit_fin = fin_en && (fin_idx == IW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[g]  <= 1'b0;
        rtr_q[g] <= 1'b0;
        ie_q[g]  <= 1'b0;
        id_q[g]  <= '0;
      end else if (hit_wr) begin
        en_q[g]  <= wr_ctrl[CTRL_EN];
        rtr_q[g] <= wr_ctrl[CTRL_RTR];
        ie_q[g]  <= wr_ctrl[CTRL_IE];
        id_q[g]  <= wr_id;
      end else if (hit_fin || kill[g]) begin
        en_q[g]  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/txobj_prio.sv
module txobj_prio #(
  parameter int N_OBJ = 32,
  localparam int IW   = $clog2(N_OBJ)
) (
  input  logic [N_OBJ-1:0] req,
  output logic             any,
  output logic [IW-1:0]    win
);
  always_comb begin
    any = |req;
    win = '0;
    for (int i = N_OBJ - 1; i >= 0; i--) begin
      if (req[i]) win = IW'(i);
    end
  end
endmodule

// File: rtl/txobj_match.sv
module txobj_match #(
  parameter int N_OBJ = 32,
  parameter int ID_W  = 29
) (
  input  logic                       hit,
  input  logic [ID_W-1:0]            hit_id,
  input  logic [N_OBJ-1:0]           en,
  input  logic [N_OBJ-1:0]           rtr,
  input  logic [N_OBJ-1:0][ID_W-1:0] id,
  output logic [N_OBJ-1:0]           kill
);
  for (genvar g = 0; g < N_OBJ; g++) begin : g_cmp
    assign kill[g] = hit && en[g] && rtr[g] && (id[g] == hit_id);
  end
endmodule

// File: rtl/can_txobj_arb.sv
module can_txobj_arb #(
  parameter int N_OBJ = 32,
  parameter int ID_W  = 29,
  localparam int IW   = $clog2(N_OBJ)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [IW-1:0]    cfg_idx,
  input  logic [2:0]       cfg_ctrl,
  input  logic [ID_W-1:0]  cfg_id,
  input  logic             core_done,
  input  logic             core_ok,
  input  logic             rx_match,
  input  logic [ID_W-1:0]  rx_id,
  output logic             sel_valid,
  output logic [IW-1:0]    sel_idx,
  output logic             sel_rtr,
  output logic [N_OBJ-1:0] irq
);
  logic [N_OBJ-1:0]           en_q, rtr_q, ie_q, kill;
  logic [N_OBJ-1:0][ID_W-1:0] id_q;
  logic                       busy, any, fin;
  logic [IW-1:0]              win;

  assign fin = busy && core_done && core_ok;

  txobj_bank #(.N_OBJ(N_OBJ), .ID_W(ID_W)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_ctrl(cfg_ctrl), .wr_id(cfg_id),
    .fin_en(fin), .fin_idx(sel_idx), .kill(kill),
    .en_q(en_q), .rtr_q(rtr_q), .ie_q(ie_q), .id_q(id_q)
  );

  txobj_match #(.N_OBJ(N_OBJ), .ID_W(ID_W)) u_match (
    .hit(rx_match), .hit_id(rx_id), .en(en_q), .rtr(rtr_q), .id(id_q),
    .kill(kill)
  );

  txobj_prio #(.N_OBJ(N_OBJ)) u_prio (.req(en_q), .any(any), .win(win));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      sel_valid <= 1'b0;
      sel_idx   <= '0;
      sel_rtr   <= 1'b0;
      irq       <= '0;
    end else begin
      sel_valid <= 1'b0;
      irq       <= '0;
      if (!busy && any) begin
        busy      <= 1'b1;
        sel_valid <= 1'b1;
        sel_idx   <= win;
        sel_rtr   <= rtr_q[win];
      end else if (busy && core_done) begin
        busy <= 1'b0;
        if (fin && en_q[sel_idx] && ie_q[sel_idx] && !kill[sel_idx])
          irq[sel_idx] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_txobj_arb_chk.sv
module can_txobj_arb_chk #(
  parameter int N_OBJ = 32,
  localparam int IW   = $clog2(N_OBJ)
) (
  input logic             clk,
  input logic             rst,
  input logic             core_done,
  input logic             core_ok,
  input logic             sel_valid,
  input logic [IW-1:0]    sel_idx,
  input logic [N_OBJ-1:0] irq,
  input logic [N_OBJ-1:0] en_q
);
  logic [N_OBJ-1:0] bit_sel, below_sel;
  logic             open_q;
  assign bit_sel   = {{(N_OBJ-1){1'b0}}, 1'b1} << sel_idx;
  assign below_sel = bit_sel - {{(N_OBJ-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) open_q <= 1'b0;
    else if (sel_valid) open_q <= 1'b1;
    else if (core_done) open_q <= 1'b0;
  end

  p_sel_lowest_r3: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> (($past(en_q) & below_sel) == '0));
  p_sel_enabled_r3: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> (($past(en_q) & bit_sel) != '0));
  p_single_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    sel_valid |=> !sel_valid);
  p_no_strobe_open_r4: assert property (@(posedge clk) disable iff (rst)
    (open_q && !core_done) |=> !sel_valid);
  p_irq_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq));
  p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
    (irq != '0) |-> $past(core_done && core_ok));
  p_irq_on_sel_r7: assert property (@(posedge clk) disable iff (rst)
    (irq != '0) |-> (irq == bit_sel));
  p_fin_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (open_q && core_done && core_ok) |=> (($past(bit_sel) & en_q) == '0) || $past(bit_sel) == '0);
endmodule

bind can_txobj_arb can_txobj_arb_chk #(.N_OBJ(N_OBJ)) u_chk (
  .clk(clk), .rst(rst), .core_done(core_done), .core_ok(core_ok),
  .sel_valid(sel_valid), .sel_idx(sel_idx), .irq(irq), .en_q(en_q)
);

// File: tb/can_txobj_arb_tb.sv
`timescale 1ns/1ps
module can_txobj_arb_tb;
  localparam int N = 32;
  localparam int W = 29;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, core_done = 1'b0, core_ok = 1'b0, rx_match = 1'b0;
  logic [4:0] cfg_idx = '0;
  logic [2:0] cfg_ctrl = '0;
  logic [W-1:0] cfg_id = '0, rx_id = '0;
  logic sel_valid, sel_rtr;
  logic [4:0] sel_idx;
  logic [N-1:0] irq;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  can_txobj_arb u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_ctrl(cfg_ctrl), .cfg_id(cfg_id), .core_done(core_done),
    .core_ok(core_ok), .rx_match(rx_match), .rx_id(rx_id),
    .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_rtr(sel_rtr), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input int idx, input logic [2:0] ctrl, input logic [W-1:0] id);
    cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_ctrl = ctrl; cfg_id = id;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic done(input bit ok);
    core_done = 1'b1; core_ok = ok;
    step();
    core_done = 1'b0; core_ok = 1'b0;
  endtask

  task automatic match(input logic [W-1:0] id);
    rx_match = 1'b1; rx_id = id;
    step();
    rx_match = 1'b0;
  endtask

  task automatic expect_sel(input int idx, input string req);
    bit got = 1'b0;
    for (int c = 0; c < 10 && !got; c++) begin
      if (sel_valid) got = 1'b1; else step();
    end
    chk(got && sel_idx == 5'(idx), req, got ? sel_idx : 99, idx);
    if (got) step();
  endtask

  task automatic expect_quiet(input int cyc, input string req);
    bit seen = 1'b0;
    for (int c = 0; c < cyc; c++) begin
      if (sel_valid) seen = 1'b1;
      step();
    end
    chk(!seen, req, seen, 0);
  endtask

  initial begin
    #800000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk); step(); step();
    rst = 1'b0;
    chk(sel_valid == 1'b0, "R1 sel_valid", sel_valid, 0);
    chk(irq == '0, "R1 irq", irq, 0);
    expect_quiet(4, "R1 nothing enabled");

    // R2 exact latency, then sweep every object through R5/R7
    for (int i = 0; i < N; i++) begin
      wr(i, 3'b110, W'(i));
      if (i == 0) begin
        chk(sel_valid == 1'b0, "R2 first cycle", sel_valid, 0);
        step();
        chk(sel_valid == 1'b1 && sel_idx == 0, "R2 second cycle", sel_valid, 1);
        chk(sel_rtr == 1'b0, "R11 data frame", sel_rtr, 0);
        step();
      end else begin
        expect_sel(i, "R2 sweep select");
      end
      expect_quiet(2, "R4 no restrobe while open");
      done(1'b1);
      chk(irq == (32'h1 << i), "R7 irq bit", irq, 32'h1 << i);
      step();
      chk(irq == '0, "R7 irq one cycle", irq, 0);
      expect_quiet(3, "R5 enable cleared");
    end

    // R3/R10: occupy core with 31, queue same-id fragment objects
    wr(31, 3'b110, 29'h55);
    expect_sel(31, "R3 holder");
    for (int k = 0; k < 31; k++)
      if ((k * 7) % 5 == 0 || k % 6 == 1) wr(k, 3'b110, 29'h155);
    done(1'b1);
    for (int k = 0; k < 31; k++)
      if ((k * 7) % 5 == 0 || k % 6 == 1) begin
        expect_sel(k, "R10 ascending fragment order");
        done(1'b1);
        chk(irq == (32'h1 << k), "R7 fragment irq", irq, 32'h1 << k);
      end
    expect_quiet(3, "R3 queue drained");

    // R6 failure retries
    wr(9, 3'b110, 29'h9);
    expect_sel(9, "R6 first try");
    done(1'b0);
    chk(irq == '0, "R6 no irq on fail", irq, 0);
    expect_sel(9, "R6 retry");
    done(1'b1);
    chk(irq == (32'h1 << 9), "R6 irq after retry", irq, 32'h1 << 9);

    // R7 irq disabled, R11 remote frame
    wr(4, 3'b101, 29'h44);
    bit_tmp_check: begin
      bit got = 1'b0;
      for (int c = 0; c < 10 && !got; c++) if (sel_valid) got = 1'b1; else step();
      chk(got && sel_idx == 4 && sel_rtr, "R11 rtr flag", sel_rtr, 1);
      step();
    end
    done(1'b1);
    chk(irq == '0, "R7 ie off", irq, 0);
    expect_quiet(3, "R5 rtr enable cleared");

    // R8 cancellation in pre-arbitration, data object with same id kept
    wr(3, 3'b110, 29'hA);
    expect_sel(3, "R8 holder");
    wr(6, 3'b111, 29'hB);
    wr(8, 3'b110, 29'hB);
    match(29'hB);
    chk(irq == '0, "R8 no irq on cancel", irq, 0);
    done(1'b1);
    expect_sel(8, "R8 rtr cancelled, data kept");
    done(1'b1);
    chk(irq == (32'h1 << 8), "R8 data irq", irq, 32'h1 << 8);
    expect_quiet(3, "R8 cancelled object gone");

    // R9 cancel during transmission
    wr(12, 3'b111, 29'hC);
    expect_sel(12, "R9 select");
    match(29'hC);
    done(1'b1);
    chk(irq == '0, "R9 no irq", irq, 0);
    expect_quiet(3, "R9 not resent");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule